// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a chain of boundary-scan cells placed between core logic and the device pins. Each cell is one of three kinds. An input cell samples a pin. An output data cell drives a pin value. A control cell switches the output drivers of a group of output data cells. A bidirectional pin uses all three: an input cell, an output data cell and a control cell. Every cell has a capture/shift stage, clocked on the rising edge of the test clock. It also has an update stage, clocked on the falling edge, and that stage holds its value while a new pattern is shifted in.

The test access port controller supplies the strobes: capture, shift, update and test-logic-reset. A select line marks when this chain is the active data register. The instruction decoder supplies three mode lines: external test, clamp and high impedance.
- In functional mode the pins carry the core's values and enables.
- Under external test or clamp they are driven from the update stages.
- High impedance turns every driver off.

The cell kinds, the control cell that serves each output, the value that disables each control cell, and the safe value of every cell are all parameters.

Top module: `bsc_chain`

## Requirements
- R1: Cell 0 is the cell nearest the serial output. After a capture, the first bit seen on `tdo` is cell 0, followed by the cells in increasing index on each shifting rising edge. After N_CELLS shifts, the bit presented on `tdi` in shift k (counting from 0) sits in cell k.
- R2: On a rising edge with `capture_dr` and `bsr_sel` both high, each input cell captures `pin_in[i]`. Each output data cell (IS_OUT bit 1) and each control cell (IS_CTL bit 1) captures `core_val[i]`.
- R3: The update stage loads from the capture/shift stage on a falling edge with `update_dr` and `bsr_sel` both high. Otherwise it holds, including throughout shifting.
- R4: When `bsr_sel` is low, `capture_dr`, `shift_dr` and `update_dr` have no effect on either stage.
- R5: With all mode lines low, each output data cell i drives `pin_out[i] = core_val[i]`. It drives `pin_oe[i] = 1` unless `core_val[c]` equals DIS_VAL[c], where c is the control cell that CTL_IDX assigns to cell i.
- R6: With `mode_extest` or `mode_clamp` high, each output data cell drives its update-stage value. Its `pin_oe` is 1 unless the update stage of its control cell equals that cell's DIS_VAL bit.
- R7: `mode_hiz` forces every `pin_oe` to 0, and takes priority over external test and clamp.
- R8: Asserting `trst_n` low loads both stages of every cell with its SAFE bit. A falling edge with `tlr` high loads every update stage with its SAFE bit.
- R9: Cells that are not output data cells always drive `pin_out = 0` and `pin_oe = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data into the highest-index cell |
| tdo | output | 1 | Serial data from cell 0 |
| bsr_sel | input | 1 | This chain is the selected data register |
| capture_dr | input | 1 | Capture strobe, acts on the rising edge |
| shift_dr | input | 1 | Shift strobe, acts on the rising edge |
| update_dr | input | 1 | Update strobe, acts on the falling edge |
| tlr | input | 1 | Test-logic-reset state, loads safe values into the update stages |
| mode_extest | input | 1 | Drive pins from the update stages |
| mode_clamp | input | 1 | Drive pins from the update stages while another register is scanned |
| mode_hiz | input | 1 | Turn off all output drivers |
| core_val | input | N_CELLS | Core-side value per cell (data for output cells, enable value for control cells) |
| pin_in | input | N_CELLS | Pin value per cell (used by input cells) |
| pin_out | output | N_CELLS | Pin drive value per cell |
| pin_oe | output | N_CELLS | Pin driver enable per cell |

## Verification
A capture shows up on `tdo` right after the capturing rising edge. Each shift moves the chain one place per rising edge. A new update value reaches the pins after the falling edge that falls in the middle of the update cycle. Mode-line changes reach the pins combinationally. The bench changes its inputs 1 ns after a rising edge and reads `tdo` 1 ns after that, before the next edge. It checks the pins only after the falling edge of the update cycle and the next rising edge, so every comparison sees a settled value. Random pin, core and scan patterns from a fixed seed are checked against values that bench functions compute from the cell table. Directed cases cover a stall in the middle of a shift, a deselected chain, high impedance with external test, clamp, and a test-logic-reset pulse.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  // Source of each pin's drive and enable.
  typedef enum logic [1:0] {
    DRV_FUNC = 2'd0,
    DRV_SCAN = 2'd1,
    DRV_OFF  = 2'd2
  } drive_sel_e;

  // Strobes after gating with the register select.
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } bsc_strobe_t;

endpackage

// File: rtl/bsc_rst_sync.sv
module bsc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic meta_q;
  logic meta_d;
  logic rst_d;

  always_comb begin
    meta_d = 1'b1;
    rst_d  = meta_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      rst_n  <= 1'b0;
    end else begin
      meta_q <= meta_d;
      rst_n  <= rst_d;
    end
  end
endmodule

// File: rtl/bsc_cell.sv
module bsc_cell #(
  parameter logic SAFE = 1'b0
) (
  input  logic tck,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic tlr,
  input  logic cap_src,
  input  logic scan_in,
  output logic scan_q,
  output logic upd_q
);
  logic scan_d;
  logic upd_d;

  // Capture/shift stage: capture wins over shift.
  always_comb begin
    scan_d = scan_q;
    if (cap_en) begin
      scan_d = cap_src;
    end else if (shift_en) begin
      scan_d = scan_in;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      scan_q <= SAFE;
    end else begin
      scan_q <= scan_d;
    end
  end

  // Update stage on the falling edge: test-logic-reset wins over update.
  always_comb begin
    upd_d = upd_q;
    if (tlr) begin
      upd_d = SAFE;
    end else if (upd_en) begin
      upd_d = scan_q;
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= SAFE;
    end else begin
      upd_q <= upd_d;
    end
  end
endmodule

// File: rtl/bsc_mode_sel.sv
module bsc_mode_sel
  import bsc_pkg::*;
(
  input  logic       mode_extest,
  input  logic       mode_clamp,
  input  logic       mode_hiz,
  output drive_sel_e drv
);
  always_comb begin
    if (mode_hiz) begin
      drv = DRV_OFF;
    end else if (mode_extest || mode_clamp) begin
      drv = DRV_SCAN;
    end else begin
      drv = DRV_FUNC;
    end
  end
endmodule

// File: rtl/bsc_pin_drv.sv
module bsc_pin_drv
  import bsc_pkg::*;
#(
  parameter logic DIS = 1'b1
) (
  input  drive_sel_e drv,
  input  logic       core_d,
  input  logic       core_ctl,
  input  logic       upd_d,
  input  logic       upd_ctl,
  output logic       pin_q,
  output logic       oe_q
);
  always_comb begin
    case (drv)
      DRV_SCAN: begin
        pin_q = upd_d;
        oe_q  = (upd_ctl != DIS);
      end
      DRV_OFF: begin
        pin_q = core_d;
        oe_q  = 1'b0;
      end
      default: begin
        pin_q = core_d;
        oe_q  = (core_ctl != DIS);
      end
    endcase
  end
endmodule

// File: rtl/bsc_chain.sv
module bsc_chain
  import bsc_pkg::*;
#(
  parameter int                        N_CELLS = 12,
  parameter int                        IDX_W   = (N_CELLS > 1) ? $clog2(N_CELLS) : 1,
  parameter logic [N_CELLS-1:0]        IS_OUT  = 12'h926,
  parameter logic [N_CELLS-1:0]        IS_CTL  = 12'h248,
  parameter logic [N_CELLS*IDX_W-1:0]  CTL_IDX = 48'h3009_0060_0330,
  parameter logic [N_CELLS-1:0]        DIS_VAL = 12'h208,
  parameter logic [N_CELLS-1:0]        SAFE    = 12'h20C
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tdi,
  output logic               tdo,
  input  logic               bsr_sel,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               tlr,
  input  logic               mode_extest,
  input  logic               mode_clamp,
  input  logic               mode_hiz,
  input  logic [N_CELLS-1:0] core_val,
  input  logic [N_CELLS-1:0] pin_in,
  output logic [N_CELLS-1:0] pin_out,
  output logic [N_CELLS-1:0] pin_oe
);
  localparam logic [N_CELLS-1:0] IN_MASK = ~(IS_OUT | IS_CTL);

  logic               rst_s;
  bsc_strobe_t        stb;
  logic               cap_en;
  logic               shift_en;
  logic               upd_en;
  drive_sel_e         drv;
  logic [N_CELLS-1:0] cap_src;
  logic [N_CELLS-1:0] link_in;
  logic [N_CELLS-1:0] scan_q;
  logic [N_CELLS-1:0] upd_q;

  bsc_rst_sync u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_s)
  );

  always_comb begin
    stb.capture = capture_dr && bsr_sel;
    stb.shift   = shift_dr   && bsr_sel;
    stb.update  = update_dr  && bsr_sel;
    cap_en      = stb.capture;
    shift_en    = stb.shift;
    upd_en      = stb.update;
  end

  // Input cells look at the pin, all others at the core side.
  assign cap_src = (pin_in & IN_MASK) | (core_val & ~IN_MASK);

  // Serial link: tdi enters the top cell, each cell feeds the one below.
  generate
    if (N_CELLS > 1) begin : g_link
      assign link_in = {tdi, scan_q[N_CELLS-1:1]};
    end else begin : g_link1
      assign link_in = tdi;
    end
  endgenerate

  assign tdo = scan_q[0];

  bsc_mode_sel u_mode (
    .mode_extest (mode_extest),
    .mode_clamp  (mode_clamp),
    .mode_hiz    (mode_hiz),
    .drv         (drv)
  );

  generate
    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      bsc_cell #(.SAFE(SAFE[i])) u_cell (
        .tck      (tck),
        .rst_n    (rst_s),
        .cap_en   (cap_en),
        .shift_en (shift_en),
        .upd_en   (upd_en),
        .tlr      (tlr),
        .cap_src  (cap_src[i]),
        .scan_in  (link_in[i]),
        .scan_q   (scan_q[i]),
        .upd_q    (upd_q[i])
      );

      if (IS_OUT[i]) begin : g_out
        localparam int C = int'(CTL_IDX[IDX_W*i +: IDX_W]);
        bsc_pin_drv #(.DIS(DIS_VAL[C])) u_drv (
          .drv      (drv),
          .core_d   (core_val[i]),
          .core_ctl (core_val[C]),
          .upd_d    (upd_q[i]),
          .upd_ctl  (upd_q[C]),
          .pin_q    (pin_out[i]),
          .oe_q     (pin_oe[i])
        );
      end else begin : g_nodrv
        assign pin_out[i] = 1'b0;
        assign pin_oe[i]  = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/bsc_chain_chk.sv
module bsc_chain_chk #(
  parameter int                 N_CELLS = 12,
  parameter logic [N_CELLS-1:0] IS_OUT  = 12'h926,
  parameter logic [N_CELLS-1:0] SAFE    = 12'h20C
) (
  input logic               tck,
  input logic               rst_s,
  input logic               tdi,
  input logic               bsr_sel,
  input logic               tlr,
  input logic               mode_extest,
  input logic               mode_clamp,
  input logic               mode_hiz,
  input logic               cap_en,
  input logic               shift_en,
  input logic               upd_en,
  input logic [N_CELLS-1:0] cap_src,
  input logic [N_CELLS-1:0] scan_q,
  input logic [N_CELLS-1:0] upd_q,
  input logic [N_CELLS-1:0] core_val,
  input logic [N_CELLS-1:0] pin_out,
  input logic [N_CELLS-1:0] pin_oe
);
  // R1: one place toward the output per shift, tdi enters at the top
  assert_shift_order_R1: assert property (@(posedge tck) disable iff (!rst_s)
    (shift_en && !cap_en) |=> (scan_q == {$past(tdi), $past(scan_q) >> 1} ||
                               scan_q == ({$past(tdi), $past(scan_q)} >> 1)));

  // R2: the capture stage takes the selected source
  assert_capture_R2: assert property (@(posedge tck) disable iff (!rst_s)
    cap_en |=> (scan_q == $past(cap_src)));

  // R3: the update stage holds without an update strobe
  assert_update_hold_R3: assert property (@(negedge tck) disable iff (!rst_s)
    (!upd_en && !tlr) |=> $stable(upd_q));

  // R4: a deselected chain does not move
  assert_desel_hold_R4: assert property (@(posedge tck) disable iff (!rst_s)
    !bsr_sel |=> $stable(scan_q));

  // R5: functional mode passes core data to the output pins
  assert_func_data_R5: assert property (@(posedge tck) disable iff (!rst_s)
    (!mode_extest && !mode_clamp && !mode_hiz) |-> ((pin_out & IS_OUT) == (core_val & IS_OUT)));

  // R7: high impedance disables every driver
  assert_hiz_off_R7: assert property (@(posedge tck) disable iff (!rst_s)
    mode_hiz |-> (pin_oe == '0));

  // R8: test-logic-reset restores the safe values
  assert_tlr_safe_R8: assert property (@(negedge tck) disable iff (!rst_s)
    tlr |=> (upd_q == SAFE));

  // R9: only output data cells drive
  assert_nodrv_R9: assert property (@(posedge tck) disable iff (!rst_s)
    (((pin_oe | pin_out) & ~IS_OUT) == '0));
endmodule

bind bsc_chain bsc_chain_chk #(
  .N_CELLS (N_CELLS),
  .IS_OUT  (IS_OUT),
  .SAFE    (SAFE)
) u_chk (
  .tck         (tck),
  .rst_s       (rst_s),
  .tdi         (tdi),
  .bsr_sel     (bsr_sel),
  .tlr         (tlr),
  .mode_extest (mode_extest),
  .mode_clamp  (mode_clamp),
  .mode_hiz    (mode_hiz),
  .cap_en      (cap_en),
  .shift_en    (shift_en),
  .upd_en      (upd_en),
  .cap_src     (cap_src),
  .scan_q      (scan_q),
  .upd_q       (upd_q),
  .core_val    (core_val),
  .pin_out     (pin_out),
  .pin_oe      (pin_oe)
);

// File: tb/tb_bsc_chain.sv
module tb_bsc_chain;
  localparam int             N    = 12;
  localparam int             IW   = 4;
  localparam logic [N-1:0]    ISO  = 12'h926;
  localparam logic [N-1:0]    ISC  = 12'h248;
  localparam logic [N*IW-1:0] CIDX = 48'h3009_0060_0330;
  localparam logic [N-1:0]    DISV = 12'h208;
  localparam logic [N-1:0]    SAFEV = 12'h20C;
  localparam logic [N-1:0]    INM  = ~(ISO | ISC);

  logic         tck;
  logic         trst_n;
  logic         tdi;
  logic         tdo;
  logic         bsr_sel;
  logic         capture_dr;
  logic         shift_dr;
  logic         update_dr;
  logic         tlr;
  logic         mode_extest;
  logic         mode_clamp;
  logic         mode_hiz;
  logic [N-1:0] core_val;
  logic [N-1:0] pin_in;
  logic [N-1:0] pin_out;
  logic [N-1:0] pin_oe;

  int  n_chk;
  int  n_fail;
  bit  done;

  bsc_chain #(
    .N_CELLS (N), .IDX_W (IW), .IS_OUT (ISO), .IS_CTL (ISC),
    .CTL_IDX (CIDX), .DIS_VAL (DISV), .SAFE (SAFEV)
  ) dut (
    .tck (tck), .trst_n (trst_n), .tdi (tdi), .tdo (tdo),
    .bsr_sel (bsr_sel), .capture_dr (capture_dr), .shift_dr (shift_dr),
    .update_dr (update_dr), .tlr (tlr), .mode_extest (mode_extest),
    .mode_clamp (mode_clamp), .mode_hiz (mode_hiz), .core_val (core_val),
    .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe)
  );

  initial tck = 1'b0;
  always #10 tck = ~tck;

  function automatic logic [N-1:0] exp_oe(input logic [N-1:0] v);
    logic [N-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      if (ISO[i]) begin
        int c;
        c = int'(CIDX[IW*i +: IW]);
        r[i] = (v[c] != DISV[c]);
      end
    end
    return r;
  endfunction

  function automatic logic [N-1:0] exp_cap(input logic [N-1:0] p, input logic [N-1:0] c);
    return (p & INM) | (c & ~INM);
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Capture, shift N bits, update; optional check of the held pins mid-shift.
  task automatic scan(input logic [N-1:0] din, output logic [N-1:0] dout,
                      input bit mid_chk, input logic [N-1:0] held);
    capture_dr = 1'b1;
    @(posedge tck); #1;
    capture_dr = 1'b0;
    shift_dr   = 1'b1;
    for (int i = 0; i < N; i++) begin
      tdi = din[i];
      #1;
      dout[i] = tdo;
      if (mid_chk && i == N/2) begin
        chk("R3 pins hold while shifting", pin_out, held & ISO);
      end
      @(posedge tck); #1;
    end
    shift_dr  = 1'b0;
    update_dr = 1'b1;
    @(posedge tck); #1;
    update_dr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [N-1:0] din;
    logic [N-1:0] dout;
    logic [N-1:0] last;
    n_chk = 0; n_fail = 0; done = 1'b0;
    void'($urandom(32'h0BAD_5EED));
    trst_n = 1'b0; tdi = 1'b0; bsr_sel = 1'b0; capture_dr = 1'b0;
    shift_dr = 1'b0; update_dr = 1'b0; tlr = 1'b0; mode_extest = 1'b0;
    mode_clamp = 1'b0; mode_hiz = 1'b0; core_val = '0; pin_in = '0;
    repeat (3) @(posedge tck);
    #1 trst_n = 1'b1;
    repeat (4) @(posedge tck);
    #2;

    // R8: reset state of both stages
    chk("R8 reset capture stage on tdo", N'(tdo), N'(SAFEV[0]));
    mode_extest = 1'b1; #1;
    chk("R8 reset update pins", pin_out, SAFEV & ISO);
    chk("R8 reset update enables", pin_oe, exp_oe(SAFEV));
    mode_extest = 1'b0; #1;

    // R5/R9: functional mode with random core values
    for (int k = 0; k < 6; k++) begin
      core_val = N'($urandom);
      pin_in   = N'($urandom);
      #2;
      chk("R5 functional data", pin_out, core_val & ISO);
      chk("R5 functional enables", pin_oe, exp_oe(core_val));
      chk("R9 non-output cells quiet", (pin_out | pin_oe) & ~ISO, '0);
    end

    // R1/R2/R6: preload with capture readback, then external test drive
    bsr_sel = 1'b1;
    last = '0;
    for (int k = 0; k < 8; k++) begin
      @(posedge tck); #1;
      mode_extest = 1'b0;
      core_val = N'($urandom);
      pin_in   = N'($urandom);
      din = (k == 0) ? '1 : (k == 1) ? '0 : N'($urandom);
      scan(din, dout, 1'b0, '0);
      chk("R1 R2 captured order on tdo", dout, exp_cap(pin_in, core_val));
      mode_extest = 1'b1; #2;
      chk("R1 R6 shifted pattern on pins", pin_out, din & ISO);
      chk("R6 enables from control cells", pin_oe, exp_oe(din));
      last = din;
    end

    // R3: update stage holds while a new pattern shifts in
    din = ~last;
    scan(din, dout, 1'b1, last);
    chk("R3 pins after update", pin_out, din & ISO);
    last = din;

    // R7: high impedance over external test, and alone
    mode_hiz = 1'b1; #2;
    chk("R7 hiz with extest", pin_oe, '0);
    mode_extest = 1'b0; core_val = '1 ^ DISV; #2;
    chk("R7 hiz alone", pin_oe, '0);
    mode_hiz = 1'b0;

    // R6: clamp drives from the update stage
    mode_clamp = 1'b1; #2;
    chk("R6 clamp data", pin_out, last & ISO);
    chk("R6 clamp enables", pin_oe, exp_oe(last));

    // R4: deselected strobes are ignored
    bsr_sel = 1'b0;
    @(posedge tck); #1;
    scan(~last, dout, 1'b0, '0);
    #2;
    chk("R4 deselected update ignored", pin_out, last & ISO);
    bsr_sel = 1'b1;
    update_dr = 1'b1;
    @(posedge tck); #1;
    update_dr = 1'b0; #2;
    chk("R4 deselected shift and capture ignored", pin_out, last & ISO);
    chk("R4 enables unchanged", pin_oe, exp_oe(last));

    // R8: test-logic-reset restores safe values
    mode_clamp = 1'b0; mode_extest = 1'b1;
    tlr = 1'b1;
    @(posedge tck); #1;
    tlr = 1'b0; #2;
    chk("R8 tlr safe pins", pin_out, SAFEV & ISO);
    chk("R8 tlr safe enables", pin_oe, exp_oe(SAFEV));

    repeat (2) @(posedge tck);
    finish_run();
  end
endmodule